// File: doc/BRIEF.md
# Pipelined Burst Memory Front End

This block is a synchronous single-port memory of 32-bit words with a short burst engine in front of it. A cycle begins a burst when one of two active-low address strobes is asserted. The processor-side strobe always reads on its starting edge and is ignored while the primary chip enable is inactive. The controller-side strobe is never masked and may read or write on its starting edge. On cycles with no strobe, an active burst either steps to its next word or holds the current one. A step is requested by driving the advance input low. Holding the current word inserts a wait state.

The burst engine replaces only the two lowest address bits. The upper bits stay as captured at burst start. A static order input selects the step sequence. In XOR order, step k uses the start bits XOR k. In linear order, the low bits count up and wrap modulo 4. Writes go through four byte lanes, and there is also a global write that forces all four lanes. Read data passes through one output register. A drive flag, gated asynchronously by the output enable, stands in for the high-impedance control of a bidirectional bus.

Top module: `sbr_top`

## Requirements
- R1: `adsp_n` low together with `ce1_n` low starts a burst at `addr`. That edge is always a read, even when write enables are asserted. A write to the start address occurs on a later non-strobe cycle with `adv_n` high and write enables asserted.
- R2: `adsp_n` low while `ce1_n` is high is ignored. With `adsc_n` high, an active burst carries on as a normal continuation cycle and does not load the new address.
- R3: `adsc_n` low, with no accepted processor strobe, starts a burst at `addr`. The chip is selected only when `ce1_n` is low, `ce2` is high and `ce3_n` is low. The starting edge reads or writes according to the write enables.
- R4: `ce2` and `ce3_n` are sampled only on edges where a strobe starts a burst. Changing them during continuation cycles has no effect.
- R5: With `burst_il`=1, continuation cycles with `adv_n` low visit low address bits start^1, start^2, start^3, and then wrap back to start.
- R6: With `burst_il`=0, the low two bits go start+1, start+2 and so on, modulo 4. Address bits above bit 1 keep their captured value.
- R7: A continuation cycle with `adv_n` high repeats the current address.
- R8: `gw_n` low writes all four bytes. Otherwise lane i (bits 8i+7..8i) is written only when `bwe_n` is low and `bw_n[i]` is low. `bw_n` has no effect while `bwe_n` is high, and the cycle is then a read. Lanes that are not written keep their contents.
- R9: A read cycle's word appears on `dq_out`, with `dq_drive` high, after the edge that captures its address. The pipeline is one stage.
- R10: A strobe edge with the chip not selected ends the burst. After that, and after any write cycle, `dq_drive` is low until the next read.
- R11: `oe_n` high forces `dq_drive` low without waiting for a clock edge.
- R12: While `rst` is high and after it is released, no burst is active and `dq_drive` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| burst_il | input | 1 | Burst order: 1 XOR, 0 linear (static) |
| addr | input | AW | Word address, captured at burst start |
| ce1_n | input | 1 | Primary chip enable, active low; also masks `adsp_n` |
| ce2 | input | 1 | Secondary chip enable, active high |
| ce3_n | input | 1 | Tertiary chip enable, active low |
| adsp_n | input | 1 | Processor-side address strobe, active low |
| adsc_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write of all lanes, active low |
| bwe_n | input | 1 | Byte-write qualifier, active low |
| bw_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | 8*LANES | Write data, sampled with the write enables |
| dq_out | output | 8*LANES | Registered read data |
| dq_drive | output | 1 | High when the data bus would be driven (low means high-Z) |

## Verification
The assertions assume that `burst_il` stays fixed between resets and that strobes and write enables only change clear of the clock edge. They also assume that every word is written before it is read. The bench respects these assumptions. It changes the order input only while reset is held, drives every input one nanosecond after a rising edge, and fills the whole array with known words before any read is checked. Output enable is the only input the bench changes between edges, because the checks depend on its asynchronous effect.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

    // Per-edge command produced by the strobe decoder.
    typedef struct packed {
        logic load;   // start a burst at the external address
        logic drop;   // strobe seen but chip not selected: end the burst
        logic cont;   // continuation cycle of an active burst
        logic step;   // continuation that moves to the next word
        logic write;  // at least one byte lane written this edge
    } burst_cmd_t;

    // Low address bits for step k of a burst that started at base.
    function automatic logic [1:0] burst_low(input logic [1:0] base,
                                             input logic [1:0] k,
                                             input logic       xor_order);
        return xor_order ? (base ^ k) : (base + k);
    endfunction

endpackage

// File: rtl/sbr_decode.sv
module sbr_decode
    import sbr_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             rst,
    input  logic             active_q,
    input  logic             adsp_n,
    input  logic             adsc_n,
    input  logic             adv_n,
    input  logic             ce1_n,
    input  logic             ce2,
    input  logic             ce3_n,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    output burst_cmd_t       cmd,
    output logic [LANES-1:0] lanes
);
    logic             proc_go;
    logic             ctrl_go;
    logic             selected;
    logic [LANES-1:0] lane_req;

    always_comb begin
        // processor strobe counts only with the primary enable active
        proc_go  = !adsp_n && !ce1_n;
        ctrl_go  = !proc_go && !adsc_n;
        selected = !ce1_n && ce2 && !ce3_n;
        if (!gw_n)
            lane_req = '1;
        else if (!bwe_n)
            lane_req = ~bw_n;
        else
            lane_req = '0;

        cmd   = '0;
        lanes = '0;
        if (!rst) begin
            if (proc_go || ctrl_go) begin
                cmd.load = selected;
                cmd.drop = !selected;
                if (selected && ctrl_go)
                    lanes = lane_req;
            end else if (active_q) begin
                cmd.cont = 1'b1;
                cmd.step = !adv_n;
                lanes    = lane_req;
            end
        end
        cmd.write = |lanes;
    end

endmodule

// File: rtl/sbr_burst_ctr.sv
module sbr_burst_ctr
    import sbr_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  burst_cmd_t    cmd,
    input  logic [AW-1:0] addr,
    input  logic          xor_order,
    output logic          active_q,
    output logic [AW-1:0] cur_addr
);
    localparam int HI_W = AW - 2;

    logic [AW-1:0] base_q;
    logic [1:0]    k_q;
    logic [1:0]    k_next;
    logic [AW-1:0] base_sel;

    always_comb begin
        base_sel = cmd.load ? addr : base_q;
        if (cmd.load)
            k_next = 2'd0;
        else if (cmd.step)
            k_next = k_q + 2'd1;
        else
            k_next = k_q;
        cur_addr = {base_sel[AW-1 -: HI_W], burst_low(base_sel[1:0], k_next, xor_order)};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            base_q   <= '0;
            k_q      <= 2'd0;
        end else if (cmd.load) begin
            active_q <= 1'b1;
            base_q   <= addr;
            k_q      <= 2'd0;
        end else if (cmd.drop) begin
            active_q <= 1'b0;
        end else if (cmd.step) begin
            k_q      <= k_q + 2'd1;
        end
    end

    // R3 / R1: a burst start captures the address and restarts the count
    a_r3_load_captures: assert property (@(posedge clk) disable iff (rst)
        cmd.load |=> (active_q && k_q == 2'd0 && base_q == $past(addr)));

    // R5: an advance moves the counter by exactly one
    a_r5_step_advances: assert property (@(posedge clk) disable iff (rst)
        cmd.step |=> (k_q == $past(k_q) + 2'd1));

    // R7: a continuation without advance leaves the burst where it is
    a_r7_suspend_holds: assert property (@(posedge clk) disable iff (rst)
        (cmd.cont && !cmd.step) |=> ($stable(k_q) && $stable(base_q)));

endmodule

// File: rtl/sbr_store.sv
module sbr_store #(
    parameter int AW    = 8,
    parameter int LANES = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [LANES-1:0]   lanes,
    input  logic               rd_en,
    input  logic [AW-1:0]      addr,
    input  logic [8*LANES-1:0] wdata,
    output logic [8*LANES-1:0] rdata,
    output logic               rvalid
);
    localparam int DW    = 8 * LANES;
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (lanes[i])
                mem[addr][i*8 +: 8] <= wdata[i*8 +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= rd_en;
            if (rd_en)
                rdata <= mem[addr];
        end
    end

    // R9: a read request yields valid data one edge later
    a_r9_read_latency: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rvalid);

    // R10: a write edge leaves the output register invalid
    a_r10_write_quiet: assert property (@(posedge clk) disable iff (rst)
        (|lanes) |=> !rvalid);

endmodule

// File: rtl/sbr_top.sv
module sbr_top
    import sbr_pkg::*;
#(
    parameter int AW    = 8,
    parameter int LANES = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               burst_il,
    input  logic [AW-1:0]      addr,
    input  logic               ce1_n,
    input  logic               ce2,
    input  logic               ce3_n,
    input  logic               adsp_n,
    input  logic               adsc_n,
    input  logic               adv_n,
    input  logic               gw_n,
    input  logic               bwe_n,
    input  logic [LANES-1:0]   bw_n,
    input  logic               oe_n,
    input  logic [8*LANES-1:0] dq_in,
    output logic [8*LANES-1:0] dq_out,
    output logic               dq_drive
);
    burst_cmd_t       cmd;
    logic [LANES-1:0] lanes;
    logic             active_q;
    logic [AW-1:0]    cur_addr;
    logic             rd_en;
    logic             rd_valid;

    sbr_decode #(.LANES(LANES)) u_decode (
        .rst(rst), .active_q(active_q), .adsp_n(adsp_n), .adsc_n(adsc_n),
        .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .cmd(cmd), .lanes(lanes)
    );

    sbr_burst_ctr #(.AW(AW)) u_ctr (
        .clk(clk), .rst(rst), .cmd(cmd), .addr(addr), .xor_order(burst_il),
        .active_q(active_q), .cur_addr(cur_addr)
    );

    assign rd_en = (cmd.load || cmd.cont) && !cmd.write;

    sbr_store #(.AW(AW), .LANES(LANES)) u_store (
        .clk(clk), .rst(rst), .lanes(lanes), .rd_en(rd_en), .addr(cur_addr),
        .wdata(dq_in), .rdata(dq_out), .rvalid(rd_valid)
    );

    assign dq_drive = rd_valid && !oe_n;

    // R1: the processor strobe never writes on its starting edge
    a_r1_proc_start_reads: assert property (@(posedge clk) disable iff (rst)
        (!adsp_n && !ce1_n) |-> (lanes == '0));

    // R2: a masked processor strobe with nothing else going on stays idle
    a_r2_masked_strobe: assert property (@(posedge clk) disable iff (rst)
        (ce1_n && !adsp_n && adsc_n && !active_q) |=> (!rd_valid && !active_q));

    // R8: without global or qualified byte writes, no lane is written
    a_r8_no_stray_lane: assert property (@(posedge clk) disable iff (rst)
        (gw_n && bwe_n) |-> (lanes == '0));

    // R10: an unselected strobe ends the burst and silences the output
    a_r10_drop_silences: assert property (@(posedge clk) disable iff (rst)
        cmd.drop |=> (!active_q && !rd_valid));

endmodule

// File: tb/sbr_top_test.sv
`timescale 1ns/1ps
module sbr_top_test;
    localparam int AW = 8;
    localparam int LN = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          burst_il = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
    logic          adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
    logic          gw_n = 1'b1, bwe_n = 1'b1;
    logic [LN-1:0] bw_n = '1;
    logic          oe_n = 1'b0;
    logic [31:0]   dq_in = '0;
    logic [31:0]   dq_out;
    logic          dq_drive;

    sbr_top #(.AW(AW), .LANES(LN)) uut (
        .clk(clk), .rst(rst), .burst_il(burst_il), .addr(addr),
        .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .adsp_n(adsp_n),
        .adsc_n(adsc_n), .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n),
        .bw_n(bw_n), .oe_n(oe_n), .dq_in(dq_in), .dq_out(dq_out),
        .dq_drive(dq_drive)
    );

    always #2 clk = ~clk;   // 250 MHz

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int          due;
        bit          rd;
        logic [31:0] data;
        string       tag;
    } exp_t;
    exp_t q[$];

    // reference model state
    logic [31:0]   model [256];
    bit            m_active = 0;
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_k = 2'd0;

    function automatic logic [31:0] seed(input int a);
        logic [7:0] b;
        b = a[7:0];
        return {b, ~b, b ^ 8'h5A, b + 8'h11};
    endfunction

    // one clock of stimulus; the model predicts what the next edge produces
    task automatic drive(input logic [AW-1:0] a, input logic c1n, input logic c2,
                         input logic c3n, input logic spn, input logic scn,
                         input logic avn, input logic gwn, input logic bwen,
                         input logic [LN-1:0] bwn, input logic [31:0] d,
                         input string tag);
        bit proc, ctl, rd;
        logic [LN-1:0] req, wl;
        logic [AW-1:0] cur;
        exp_t it;
        @(posedge clk);
        #1;
        addr = a; ce1_n = c1n; ce2 = c2; ce3_n = c3n; adsp_n = spn; adsc_n = scn;
        adv_n = avn; gw_n = gwn; bwe_n = bwen; bw_n = bwn; dq_in = d;
        proc = !spn && !c1n;
        ctl  = !proc && !scn;
        req  = !gwn ? 4'hF : (!bwen ? ~bwn : 4'h0);
        wl   = 4'h0;
        rd   = 0;
        if (proc || ctl) begin
            if (!c1n && c2 && !c3n) begin
                m_active = 1; m_base = a; m_k = 2'd0;
                wl = ctl ? req : 4'h0;
            end else begin
                m_active = 0;
            end
        end else if (m_active) begin
            if (!avn) m_k = m_k + 2'd1;
            wl = req;
        end
        it.data = '0;
        if (m_active) begin
            cur = {m_base[AW-1:2], burst_il ? (m_base[1:0] ^ m_k) : (m_base[1:0] + m_k)};
            if (wl != 0) begin
                for (int i = 0; i < LN; i++)
                    if (wl[i]) model[cur][i*8 +: 8] = d[i*8 +: 8];
            end else begin
                rd = 1;
                it.data = model[cur];
            end
        end
        it.due = cyc + 1;
        it.rd  = rd;
        it.tag = tag;
        q.push_back(it);
    endtask

    // selected cycle with the common enables active
    task automatic op(input logic [AW-1:0] a, input logic spn, input logic scn,
                      input logic avn, input logic gwn, input logic bwen,
                      input logic [LN-1:0] bwn, input logic [31:0] d, input string tag);
        drive(a, 1'b0, 1'b1, 1'b0, spn, scn, avn, gwn, bwen, bwn, d, tag);
    endtask

    task automatic rd_cycle(input logic avn, input string tag);
        op(8'h00, 1'b1, 1'b1, avn, 1'b1, 1'b1, 4'hF, 32'h0, tag);
    endtask

    task automatic do_reset(input logic order);
        @(posedge clk);
        #1;
        adsp_n = 1; adsc_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; bw_n = '1;
        @(posedge clk);
        #1;
        rst = 1;
        repeat (2) @(posedge clk);
        #1;
        burst_il = order;
        m_active = 0;
        @(negedge clk);
        checks++;
        if (dq_drive !== 1'b0) begin
            errors++;
            $display("FAIL R12 reset: dq_drive=%b expected 0", dq_drive);
        end
        @(posedge clk);
        #1;
        rst = 0;
    endtask

    // monitor: compares the output against the queue
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            exp_t it;
            bit   ed;
            it = q.pop_front();
            ed = it.rd && !oe_n;
            checks++;
            if (dq_drive !== ed || (ed && dq_out !== it.data)) begin
                errors++;
                $display("FAIL %s cyc %0d: drive=%b data=%h expected drive=%b data=%h",
                         it.tag, cyc, dq_drive, dq_out, ed, it.data);
            end
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset(1'b1);
        // R12: idle after reset, nothing driven
        rd_cycle(1'b0, "R12");
        // R3: fill the array with controller-strobe global writes
        for (int a = 0; a < 256; a++) begin
            op(a[7:0], 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, seed(a), "R3");
            model[a] = seed(a);
        end
        // R10: unselected controller strobe (ce2 low) ends the burst
        drive(8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 0, "R10");
        rd_cycle(1'b0, "R10");

        // R1/R5: XOR-ordered burst from 0x26 with write enables asserted on start
        op(8'h26, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'hF, 32'hDEADBEEF, "R1");
        rd_cycle(1'b0, "R5");
        rd_cycle(1'b0, "R5");
        rd_cycle(1'b0, "R5");
        // R7: wait states repeat the word
        rd_cycle(1'b1, "R7");
        rd_cycle(1'b1, "R7");
        // R5: wrap back to the start word
        rd_cycle(1'b0, "R5");
        // R11: output enable high blocks the drive
        oe_n = 1'b1;
        rd_cycle(1'b0, "R11");
        rd_cycle(1'b1, "R11");
        oe_n = 1'b0;
        // R2: masked processor strobe with a new address: burst carries on
        drive(8'h80, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 0, "R2");
        drive(8'h81, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, 0, "R2");
        // R4: ce2/ce3_n changes during continuation are ignored
        drive(8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, 0, "R4");
        drive(8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 0, "R4");

        // R1: processor start reads, next cycle writes the start address
        op(8'h40, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 0, "R1");
        op(8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 4'hF, 32'h13579BDF, "R1");
        // R9: single controller read of it
        op(8'h40, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 0, "R9");
        rd_cycle(1'b1, "R9");

        // R8: lanes 0 and 2 only
        op(8'h41, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 4'b1010, 32'hAABBCCDD, "R8");
        op(8'h41, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 0, "R8");
        // R8: lane enables without the qualifier are a read
        op(8'h42, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'h0, 32'h01020304, "R8");
        op(8'h42, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 0, "R8");
        // R8: lane 3 via a continuation write, then read back
        op(8'h43, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 0, "R8");
        op(8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 4'b0111, 32'h77000000, "R8");
        rd_cycle(1'b1, "R8");

        // R10: ce3_n high at a strobe deselects; continuation has no effect
        drive(8'h10, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 0, "R10");
        rd_cycle(1'b0, "R10");
        // R10: ce1_n high with the controller strobe deselects as well
        op(8'h11, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 0, "R10");
        drive(8'h12, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 0, "R10");
        rd_cycle(1'b0, "R10");

        // R12: reset in the middle of a burst
        op(8'h20, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 0, "R1");
        do_reset(1'b0);
        rd_cycle(1'b0, "R12");

        // R6: linear order from 0x35, upper bits kept
        op(8'h35, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 0, "R6");
        rd_cycle(1'b0, "R6");
        rd_cycle(1'b0, "R6");
        rd_cycle(1'b0, "R6");
        rd_cycle(1'b0, "R6");
        // R6: linear write burst from 0x52 wraps within its group of four
        op(8'h52, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 32'hA0A0A0A0, "R6");
        op(8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 32'hA1A1A1A1, "R6");
        op(8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 32'hA2A2A2A2, "R6");
        op(8'h52, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 0, "R6");
        rd_cycle(1'b0, "R6");
        rd_cycle(1'b0, "R6");
        rd_cycle(1'b0, "R6");
        op(8'h50, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 0, "R6");

        rd_cycle(1'b1, "R7");
        repeat (3) @(posedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule